// File: doc/BRIEF.md
# RISC Instruction Decoder and Control

This block turns one 32-bit instruction word of a small load-store RISC subset into the signals a single-cycle or pipelined datapath needs. It is purely combinational: the word goes in, and in the same cycle the register specifiers, the extended immediate, the jump target field and the datapath controls come out. It handles three fixed layouts. The register form carries three register numbers, a shift amount and a function code. The immediate form carries two register numbers and a 16-bit constant. The jump form carries a 26-bit target.

Thirteen operations are recognised: add, sub, slt, lw, sw, beq, bne, j, addi, slti, andi, ori and lui. The immediate is extended per opcode. Arithmetic, compare, memory and branch opcodes extend it by sign. The two logic opcodes extend it with zeros. The upper-load opcode places the constant in the high half of the word. Register 0 is hard-wired to zero, so any decoded write to it is dropped. A register move written as an add with register 0 therefore needs no special case. Anything outside the subset raises an illegal-instruction flag and silences every side effect.

Top module: `riscdec_top`

## Requirements
- R1: rs_o is instr_i[25:21], rt_o is instr_i[20:16], rd_o is instr_i[15:11], and jaddr_o is instr_i[25:0], for every word, including illegal ones.
- R2: Opcode 0 with shamt 0 and funct 32, 34 or 42 decodes as add, sub or slt. alu_op_o is 0, 1 or 2, dst_sel_o is 2 (rd), alu_imm_o is 0, and there is no memory access, branch or jump. An add whose rt is 0 (a move) decodes as an ordinary add.
- R3: Opcode 35 (lw) gives mem_rd_o=1, alu_op_o=0, alu_imm_o=1 and dst_sel_o=1 (rt), with imm_o sign-extended from instr_i[15:0].
- R4: Opcode 43 (sw) gives mem_wr_o=1, reg_we_o=0, dst_sel_o=0, dst_o=0, alu_op_o=0, alu_imm_o=1 and a sign-extended imm_o. mem_rd_o and mem_wr_o are never both 1.
- R5: Opcodes 4 and 5 give br_o=1 (equal) and br_o=2 (not equal), with alu_op_o=1, alu_imm_o=0, no register or memory write, and a sign-extended imm_o.
- R6: Opcode 2 gives jump_o=1 with br_o=0 and no register or memory write.
- R7: Opcodes 8 (addi) and 10 (slti) give alu_op_o 0 and 2, alu_imm_o=1, dst_sel_o=1, and a sign-extended imm_o.
- R8: Opcodes 12 (andi) and 13 (ori) give alu_op_o 3 and 4, alu_imm_o=1, dst_sel_o=1, and imm_o zero-extended (upper 16 bits 0).
- R9: Opcode 15 (lui) gives alu_op_o=5 (pass operand B), alu_imm_o=1, dst_sel_o=1, and imm_o = {instr_i[15:0], 16'h0000}.
- R10: Any other opcode, or opcode 0 with another funct or a nonzero shamt, sets illegal_o=1. It forces reg_we_o, mem_rd_o, mem_wr_o and jump_o to 0, and br_o, alu_op_o, alu_imm_o, dst_sel_o and dst_o to 0.
- R11: dst_o is rd for dst_sel_o=2, rt for dst_sel_o=1, and 0 otherwise. reg_we_o is 1 only for a legal writing instruction whose dst_o is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs_o | output | 5 | First source register number |
| rt_o | output | 5 | Second source / immediate-form destination number |
| rd_o | output | 5 | Register-form destination number |
| dst_o | output | 5 | Resolved destination register number |
| imm_o | output | 32 | Extended or upper-placed immediate |
| jaddr_o | output | 26 | Raw jump target field |
| alu_op_o | output | 3 | 0 add, 1 sub, 2 set-less-than, 3 and, 4 or, 5 pass B |
| alu_imm_o | output | 1 | ALU operand B comes from imm_o |
| br_o | output | 2 | 0 none, 1 branch if equal, 2 branch if not equal |
| jump_o | output | 1 | Unconditional jump |
| dst_sel_o | output | 2 | 0 none, 1 rt field, 2 rd field |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| illegal_o | output | 1 | Word is outside the supported subset |

## Verification
Two functions meet on one word when a legal load names register 0 as its target. The opcode decode asks for a memory read and a register write, and the zero-register gate must then cancel only the write. The same overlap is provoked with an add whose rd is 0. The vector table covers both words, and each is judged by requiring mem_rd_o (or the ALU controls) to stay as decoded while reg_we_o falls and dst_o reads 0. A second overlap, illegal detection against field extraction, is judged by checking that the register fields still track the word while every enable is held low.

// File: rtl/riscdec_pkg.sv
package riscdec_pkg;

   localparam int OPC_W = 6;
   localparam int FNC_W = 6;

   localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
   localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
   localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;
   localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
   localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
   localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
   localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
   localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;
   localparam logic [OPC_W-1:0] OPC_LW   = 6'd35;
   localparam logic [OPC_W-1:0] OPC_SW   = 6'd43;

   localparam logic [FNC_W-1:0] FNC_ADD = 6'd32;
   localparam logic [FNC_W-1:0] FNC_SUB = 6'd34;
   localparam logic [FNC_W-1:0] FNC_SLT = 6'd42;

   typedef enum logic [2:0] {
      ALU_ADD   = 3'd0,
      ALU_SUB   = 3'd1,
      ALU_SLT   = 3'd2,
      ALU_AND   = 3'd3,
      ALU_OR    = 3'd4,
      ALU_PASSB = 3'd5
   } alu_e;

   typedef enum logic [1:0] {
      BR_NONE = 2'd0,
      BR_EQ   = 2'd1,
      BR_NE   = 2'd2
   } br_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_RT   = 2'd1,
      DST_RD   = 2'd2
   } dsel_e;

   typedef struct packed {
      alu_e  alu;
      br_e   br;
      dsel_e dsel;
      logic  wr;
      logic  mrd;
      logic  mwr;
      logic  jmp;
      logic  asrc;
      logic  sext;
      logic  upper;
      logic  ill;
   } ctrl_t;

endpackage

// File: rtl/riscdec_fields.sv
module riscdec_fields #(
   parameter int INSTR_W = 32,
   parameter int OP_W    = 6,
   parameter int REG_W   = 5,
   parameter int FUNCT_W = 6,
   parameter int IMM_W   = 16,
   parameter int JADDR_W = 26
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [OP_W-1:0]    op_o,
   output logic [REG_W-1:0]   rs_o,
   output logic [REG_W-1:0]   rt_o,
   output logic [REG_W-1:0]   rd_o,
   output logic [REG_W-1:0]   shamt_o,
   output logic [FUNCT_W-1:0] funct_o,
   output logic [IMM_W-1:0]   imm_o,
   output logic [JADDR_W-1:0] jaddr_o
);
   localparam int OP_LSB = INSTR_W - OP_W;
   localparam int RS_LSB = OP_LSB - REG_W;
   localparam int RT_LSB = RS_LSB - REG_W;
   localparam int RD_LSB = RT_LSB - REG_W;
   localparam int SH_LSB = RD_LSB - REG_W;

   assign op_o    = instr_i[OP_LSB +: OP_W];
   assign rs_o    = instr_i[RS_LSB +: REG_W];
   assign rt_o    = instr_i[RT_LSB +: REG_W];
   assign rd_o    = instr_i[RD_LSB +: REG_W];
   assign shamt_o = instr_i[SH_LSB +: REG_W];
   assign funct_o = instr_i[0 +: FUNCT_W];
   assign imm_o   = instr_i[0 +: IMM_W];
   assign jaddr_o = instr_i[0 +: JADDR_W];
endmodule

// File: rtl/riscdec_ctrl.sv
module riscdec_ctrl
   import riscdec_pkg::*;
#(
   parameter int OP_W    = 6,
   parameter int FUNCT_W = 6,
   parameter int SHAMT_W = 5
) (
   input  logic [OP_W-1:0]    op_i,
   input  logic [FUNCT_W-1:0] funct_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   output ctrl_t              ctrl_o
);
   ctrl_t c;
   logic  ok;

   always_comb begin
      c      = '0;
      c.sext = 1'b1;
      ok     = 1'b1;
      case (op_i)
         OPC_REG: begin
            c.dsel = DST_RD;
            c.wr   = 1'b1;
            ok     = (shamt_i == '0);
            case (funct_i)
               FNC_ADD: c.alu = ALU_ADD;
               FNC_SUB: c.alu = ALU_SUB;
               FNC_SLT: c.alu = ALU_SLT;
               default: ok = 1'b0;
            endcase
         end
         OPC_LW: begin
            c.asrc = 1'b1;
            c.dsel = DST_RT;
            c.wr   = 1'b1;
            c.mrd  = 1'b1;
         end
         OPC_SW: begin
            c.asrc = 1'b1;
            c.mwr  = 1'b1;
         end
         OPC_BEQ: begin
            c.alu = ALU_SUB;
            c.br  = BR_EQ;
         end
         OPC_BNE: begin
            c.alu = ALU_SUB;
            c.br  = BR_NE;
         end
         OPC_JMP: c.jmp = 1'b1;
         OPC_ADDI: begin
            c.asrc = 1'b1;
            c.dsel = DST_RT;
            c.wr   = 1'b1;
         end
         OPC_SLTI: begin
            c.alu  = ALU_SLT;
            c.asrc = 1'b1;
            c.dsel = DST_RT;
            c.wr   = 1'b1;
         end
         OPC_ANDI: begin
            c.alu  = ALU_AND;
            c.asrc = 1'b1;
            c.dsel = DST_RT;
            c.wr   = 1'b1;
            c.sext = 1'b0;
         end
         OPC_ORI: begin
            c.alu  = ALU_OR;
            c.asrc = 1'b1;
            c.dsel = DST_RT;
            c.wr   = 1'b1;
            c.sext = 1'b0;
         end
         OPC_LUI: begin
            c.alu   = ALU_PASSB;
            c.asrc  = 1'b1;
            c.dsel  = DST_RT;
            c.wr    = 1'b1;
            c.sext  = 1'b0;
            c.upper = 1'b1;
         end
         default: ok = 1'b0;
      endcase
      if (!ok) begin
         c     = '0;
         c.ill = 1'b1;
      end
      ctrl_o = c;
   end
endmodule

// File: rtl/riscdec_immgen.sv
module riscdec_immgen #(
   parameter int IMM_W     = 16,
   parameter int DATA_W    = 32,
   parameter int EXT_STYLE = 0
) (
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              sext_i,
   input  logic              upper_i,
   output logic [DATA_W-1:0] imm_o
);
   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] ext;

   generate
      if (EXT_STYLE == 0) begin : g_concat
         always_comb begin
            if (sext_i && imm_i[IMM_W-1]) ext = {{PAD_W{1'b1}}, imm_i};
            else                          ext = {{PAD_W{1'b0}}, imm_i};
         end
      end else begin : g_shift
         logic signed [DATA_W-1:0] top_aligned;
         assign top_aligned = {imm_i, {PAD_W{1'b0}}};
         always_comb begin
            if (sext_i) ext = top_aligned >>> PAD_W;
            else        ext = top_aligned >> PAD_W;
         end
      end
   endgenerate

   assign imm_o = upper_i ? {imm_i, {PAD_W{1'b0}}} : ext;
endmodule

// File: rtl/riscdec_dstsel.sv
module riscdec_dstsel
   import riscdec_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  dsel_e            dsel_i,
   input  logic             wr_i,
   input  logic [REG_W-1:0] rt_i,
   input  logic [REG_W-1:0] rd_i,
   output logic [REG_W-1:0] dst_o,
   output logic             we_o
);
   always_comb begin
      case (dsel_i)
         DST_RD:  dst_o = rd_i;
         DST_RT:  dst_o = rt_i;
         default: dst_o = '0;
      endcase
   end

   assign we_o = wr_i && (dst_o != '0);
endmodule

// File: rtl/riscdec_top.sv
module riscdec_top
   import riscdec_pkg::*;
#(
   parameter int INSTR_W   = 32,
   parameter int OP_W      = 6,
   parameter int REG_W     = 5,
   parameter int FUNCT_W   = 6,
   parameter int IMM_W     = 16,
   parameter int JADDR_W   = 26,
   parameter int DATA_W    = 32,
   parameter int EXT_STYLE = 0
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [REG_W-1:0]   rs_o,
   output logic [REG_W-1:0]   rt_o,
   output logic [REG_W-1:0]   rd_o,
   output logic [REG_W-1:0]   dst_o,
   output logic [DATA_W-1:0]  imm_o,
   output logic [JADDR_W-1:0] jaddr_o,
   output logic [2:0]         alu_op_o,
   output logic               alu_imm_o,
   output logic [1:0]         br_o,
   output logic               jump_o,
   output logic [1:0]         dst_sel_o,
   output logic               reg_we_o,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               illegal_o
);
   generate
      if (OP_W != OPC_W || FUNCT_W != FNC_W) begin : g_bad_codes
         $error("riscdec_top: opcode/funct widths must match the code tables");
      end
      if (OP_W + 4 * REG_W + FUNCT_W != INSTR_W) begin : g_bad_rfmt
         $error("riscdec_top: register format does not fill the word");
      end
      if (OP_W + 2 * REG_W + IMM_W != INSTR_W) begin : g_bad_ifmt
         $error("riscdec_top: immediate format does not fill the word");
      end
      if (OP_W + JADDR_W != INSTR_W) begin : g_bad_jfmt
         $error("riscdec_top: jump format does not fill the word");
      end
      if (DATA_W != 2 * IMM_W) begin : g_bad_data
         $error("riscdec_top: upper placement needs DATA_W == 2*IMM_W");
      end
      if (EXT_STYLE != 0 && EXT_STYLE != 1) begin : g_bad_style
         $error("riscdec_top: EXT_STYLE must be 0 or 1");
      end
   endgenerate

   logic [OP_W-1:0]    op;
   logic [REG_W-1:0]   shamt;
   logic [FUNCT_W-1:0] funct;
   logic [IMM_W-1:0]   imm_raw;
   ctrl_t              ctl;

   riscdec_fields #(
      .INSTR_W(INSTR_W), .OP_W(OP_W), .REG_W(REG_W),
      .FUNCT_W(FUNCT_W), .IMM_W(IMM_W), .JADDR_W(JADDR_W)
   ) u_fields (
      .instr_i (instr_i),
      .op_o    (op),
      .rs_o    (rs_o),
      .rt_o    (rt_o),
      .rd_o    (rd_o),
      .shamt_o (shamt),
      .funct_o (funct),
      .imm_o   (imm_raw),
      .jaddr_o (jaddr_o)
   );

   riscdec_ctrl #(
      .OP_W(OP_W), .FUNCT_W(FUNCT_W), .SHAMT_W(REG_W)
   ) u_ctrl (
      .op_i    (op),
      .funct_i (funct),
      .shamt_i (shamt),
      .ctrl_o  (ctl)
   );

   riscdec_immgen #(
      .IMM_W(IMM_W), .DATA_W(DATA_W), .EXT_STYLE(EXT_STYLE)
   ) u_imm (
      .imm_i   (imm_raw),
      .sext_i  (ctl.sext),
      .upper_i (ctl.upper),
      .imm_o   (imm_o)
   );

   riscdec_dstsel #(.REG_W(REG_W)) u_dst (
      .dsel_i (ctl.dsel),
      .wr_i   (ctl.wr),
      .rt_i   (rt_o),
      .rd_i   (rd_o),
      .dst_o  (dst_o),
      .we_o   (reg_we_o)
   );

   assign alu_op_o  = ctl.alu;
   assign alu_imm_o = ctl.asrc;
   assign br_o      = ctl.br;
   assign jump_o    = ctl.jmp;
   assign dst_sel_o = ctl.dsel;
   assign mem_rd_o  = ctl.mrd;
   assign mem_wr_o  = ctl.mwr;
   assign illegal_o = ctl.ill;
endmodule

// File: rtl/riscdec_chk.sv
module riscdec_chk #(
   parameter int OP_W   = 6,
   parameter int REG_W  = 5,
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input logic [OP_W-1:0]   op_i,
   input logic              imm_msb_i,
   input logic [REG_W-1:0]  dst_i,
   input logic [DATA_W-1:0] imm_i,
   input logic [2:0]        alu_i,
   input logic [1:0]        br_i,
   input logic              jump_i,
   input logic [1:0]        dsel_i,
   input logic              we_i,
   input logic              mrd_i,
   input logic              mwr_i,
   input logic              ill_i
);
   localparam int PAD_W = DATA_W - IMM_W;

   logic sext_op, zext_op;
   assign sext_op = (op_i == 6'd35) || (op_i == 6'd43) || (op_i == 6'd4) ||
                    (op_i == 6'd5)  || (op_i == 6'd8)  || (op_i == 6'd10);
   assign zext_op = (op_i == 6'd12) || (op_i == 6'd13);

   always_comb begin
      // R10
      illegal_quiet_chk: assert (!ill_i || (!we_i && !mrd_i && !mwr_i && !jump_i && br_i == 2'd0))
         else $error("illegal word left an enable active");
      // R11
      no_zero_write_chk: assert (!we_i || dst_i != '0)
         else $error("write enabled toward register 0");
      // R4
      mem_excl_chk: assert (!(mrd_i && mwr_i))
         else $error("memory read and write together");
      // R9
      lui_low_chk: assert (alu_i != 3'd5 || imm_i[PAD_W-1:0] == '0)
         else $error("upper-placed immediate has nonzero low half");
      // R7
      sign_ext_chk: assert (!sext_op || imm_i[DATA_W-1:IMM_W] == {PAD_W{imm_msb_i}})
         else $error("immediate not sign-extended");
      // R8
      zero_ext_chk: assert (!zext_op || imm_i[DATA_W-1:IMM_W] == '0)
         else $error("immediate not zero-extended");
      // R2
      rd_only_reg_chk: assert (dsel_i != 2'd2 || op_i == '0)
         else $error("rd selected for a non-register-format opcode");
      // R6
      jump_no_branch_chk: assert (!jump_i || (br_i == 2'd0 && !we_i && !mwr_i))
         else $error("jump with a branch or write");
   end
endmodule

bind riscdec_top riscdec_chk #(
   .OP_W(OP_W), .REG_W(REG_W), .DATA_W(DATA_W), .IMM_W(IMM_W)
) u_chk (
   .op_i      (instr_i[INSTR_W-1 -: OP_W]),
   .imm_msb_i (instr_i[IMM_W-1]),
   .dst_i     (dst_o),
   .imm_i     (imm_o),
   .alu_i     (alu_op_o),
   .br_i      (br_o),
   .jump_i    (jump_o),
   .dsel_i    (dst_sel_o),
   .we_i      (reg_we_o),
   .mrd_i     (mem_rd_o),
   .mwr_i     (mem_wr_o),
   .ill_i     (illegal_o)
);

// File: tb/riscdec_tb.sv
module riscdec_top_tb_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [31:0] instr;
   logic [4:0]  rs, rt, rd, dst;
   logic [31:0] imm;
   logic [25:0] jaddr;
   logic [2:0]  alu;
   logic        asrc, jmp, we, mrd, mwr, ill;
   logic [1:0]  br, dsel;

   riscdec_top dut_i (
      .instr_i(instr), .rs_o(rs), .rt_o(rt), .rd_o(rd), .dst_o(dst),
      .imm_o(imm), .jaddr_o(jaddr), .alu_op_o(alu), .alu_imm_o(asrc),
      .br_o(br), .jump_o(jmp), .dst_sel_o(dsel), .reg_we_o(we),
      .mem_rd_o(mrd), .mem_wr_o(mwr), .illegal_o(ill)
   );

   int runs = 0;
   int fails = 0;
   bit done = 1'b0;

   function automatic logic [31:0] enc_r(int s, int t, int d, int sh, int fn);
      return {6'd0, 5'(s), 5'(t), 5'(d), 5'(sh), 6'(fn)};
   endfunction
   function automatic logic [31:0] enc_i(int op, int s, int t, int im);
      return {6'(op), 5'(s), 5'(t), 16'(im)};
   endfunction

   // expected: alu(3) br(2) dsel(2) we mrd mwr jmp asrc ill dst(5)
   typedef struct packed {
      logic [31:0] ins;
      logic [2:0]  alu;
      logic [1:0]  br;
      logic [1:0]  dsel;
      logic        we, mr, mw, jp, as, il;
      logic [4:0]  dst;
      logic        ichk;
      logic [31:0] imm;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      // R2 add $9,$17,$18
      '{enc_r(17,18,9,0,32),    3'd0,2'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,5'd9, 1'b0,32'h0,        4'd2},
      // R2 sub
      '{enc_r(1,2,3,0,34),      3'd1,2'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,5'd3, 1'b0,32'h0,        4'd2},
      // R2 slt
      '{enc_r(17,18,8,0,42),    3'd2,2'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,5'd8, 1'b0,32'h0,        4'd2},
      // R2 move as add with register 0
      '{enc_r(9,0,8,0,32),      3'd0,2'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,5'd8, 1'b0,32'h0,        4'd2},
      // R3 lw positive offset
      '{enc_i(35,18,9,32),      3'd0,2'd0,2'd1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,5'd9, 1'b1,32'h20,       4'd3},
      // R3 lw negative offset
      '{enc_i(35,4,15,16'hFFFC),3'd0,2'd0,2'd1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,5'd15,1'b1,32'hFFFFFFFC, 4'd3},
      // R4 sw
      '{enc_i(43,18,9,16'h8000),3'd0,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,5'd0, 1'b1,32'hFFFF8000, 4'd4},
      // R5 beq
      '{enc_i(4,4,5,16'hFFFF),  3'd1,2'd1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,32'hFFFFFFFF, 4'd5},
      // R5 bne
      '{enc_i(5,16,17,16),      3'd1,2'd2,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,32'h10,       4'd5},
      // R6 j
      '{{6'd2,26'h3ABCDEF},     3'd0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,5'd0, 1'b0,32'h0,        4'd6},
      // R7 addi negative
      '{enc_i(8,29,29,16'hFFFB),3'd0,2'd0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,5'd29,1'b1,32'hFFFFFFFB, 4'd7},
      // R7 slti
      '{enc_i(10,18,8,10),      3'd2,2'd0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,5'd8, 1'b1,32'hA,        4'd7},
      // R8 andi with high bit set
      '{enc_i(12,29,29,16'h8006),3'd3,2'd0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,5'd29,1'b1,32'h00008006,4'd8},
      // R8 ori
      '{enc_i(13,8,8,16'hAAAA), 3'd4,2'd0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,5'd8, 1'b1,32'h0000AAAA, 4'd8},
      // R9 lui
      '{enc_i(15,0,8,16'hAAAA), 3'd5,2'd0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,5'd8, 1'b1,32'hAAAA0000, 4'd9},
      // R10 undefined opcode
      '{enc_i(63,1,2,16'h1234), 3'd0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0, 1'b0,32'h0,        4'd10},
      // R10 undefined funct
      '{enc_r(1,2,3,0,0),       3'd0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0, 1'b0,32'h0,        4'd10},
      // R10 nonzero shamt on add
      '{enc_r(1,2,3,1,32),      3'd0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0, 1'b0,32'h0,        4'd10},
      // R11 add to register 0: write dropped
      '{enc_r(1,2,0,0,32),      3'd0,2'd0,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 1'b0,32'h0,        4'd11},
      // R11 lw to register 0: read kept, write dropped
      '{enc_i(35,3,0,8),        3'd0,2'd0,2'd1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,5'd0, 1'b1,32'h8,        4'd11}
   };

   task automatic check(input string req, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      runs++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic apply(input logic [31:0] w);
      @(negedge clk);
      instr = w;
      #2;
   endtask

   initial begin
      instr = 32'h0;
      repeat (3) @(posedge clk);
      // R10: all-zero word held during reset decodes as illegal and quiet
      #2;
      check("R10", "reset word", {58'd0, ill, we, mrd, mwr, jmp, br != 2'd0},
            {58'd0, 1'b1, 5'b00000});
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", VEC[i].req);
         apply(VEC[i].ins);
         check(tag, $sformatf("ctrl vec %0d", i),
               {46'd0, alu, br, dsel, we, mrd, mwr, jmp, asrc, ill, dst},
               {46'd0, VEC[i].alu, VEC[i].br, VEC[i].dsel, VEC[i].we, VEC[i].mr,
                VEC[i].mw, VEC[i].jp, VEC[i].as, VEC[i].il, VEC[i].dst});
         if (VEC[i].ichk)
            check(tag, $sformatf("imm vec %0d", i), {32'd0, imm}, {32'd0, VEC[i].imm});
      end

      // R1: field extraction on a legal and on an illegal word
      apply(enc_r(21, 10, 19, 0, 32));
      check("R1", "fields add", {49'd0, rs, rt, rd}, {49'd0, 5'd21, 5'd10, 5'd19});
      apply(32'hFFFF_FFFF);
      check("R1", "fields all-ones", {23'd0, rs, rt, rd, jaddr},
            {23'd0, 5'd31, 5'd31, 5'd31, 26'h3FFFFFF});
      apply({6'd2, 26'h3ABCDEF});
      check("R6", "jump target", {38'd0, jaddr}, {38'd0, 26'h3ABCDEF});
      // R9: lui with all-ones immediate keeps low half clear
      apply(enc_i(15, 7, 7, 16'hFFFF));
      check("R9", "lui ffff", {32'd0, imm}, {32'd0, 32'hFFFF0000});
      // R8: ori with all-ones immediate stays zero-extended
      apply(enc_i(13, 7, 7, 16'hFFFF));
      check("R8", "ori ffff", {32'd0, imm}, {32'd0, 32'h0000FFFF});

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         runs++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", runs, fails);
         $finish;
      end
   end

endmodule